// File: doc/BRIEF.md
# Read-Sequence Unlock Detector for Nonvolatile Store and Recall

This block watches the access stream of an 8K-by-8 static memory and spots the one fixed chain of six read addresses that asks the nonvolatile controller to copy the array into its shadow cells (store) or to copy the shadow cells back into the array (recall). Each access is taken once, in the clock cycle in which the active-low chip enable is seen to fall. In that cycle the block also samples the 13-bit address and the write-enable level. Because unlocking uses read cycles only, ordinary software that reads and writes the memory in the usual way never sets off a nonvolatile operation by chance.

The first five addresses of the chain are the same for both operations. The sixth address picks the operation. When the chain completes, the block raises a one-cycle request pulse toward the nonvolatile controller. While that controller reports busy, the block is held idle: its progress is cleared and every access is ignored. Progress is kept as a small step counter. A write or an out-of-order read drops the counter back to idle. A read of the first chain address instead restarts the chain with that read as step one.

Top module: `nvseq_unlock_detector`

## Requirements
- R1: An access is counted only in the clock cycle in which `ce_n` is sampled low after having been sampled high. Keeping `ce_n` low, and changing `addr` while it stays low, adds no further accesses.
- R2: Reads (`we_n` high) of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0 in that order, followed by a read of 0x0F0F, make `store_req` high for the one cycle after the clock edge that samples the sixth access.
- R3: The same five reads followed by a read of 0x0F0E make `recall_req` high for the one cycle after the clock edge that samples the sixth access.
- R4: An access sampled with `we_n` low (a write) at any step, including a write to the sixth address, returns the detector to idle and gives no request.
- R5: A read that is not the next expected address aborts the chain and returns the detector to idle. A second read of the address that was just accepted also counts as such a read.
- R6: A read of 0x0000 that aborts the chain, including one at the sixth step or a repeat of 0x0000, is taken as the first step of a new chain.
- R7: While `nv_busy` is high, progress is cleared, accesses are ignored and no request is issued. A chain must start again from its first address after busy ends.
- R8: Both request outputs are low after reset. They are never high together, and each pulse lasts exactly one cycle.
- R9: After the five common reads, a read of any address other than 0x0F0F or 0x0F0E gives no request and aborts the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable; each falling edge marks one access |
| we_n | input | 1 | Active-low write enable, sampled with the access |
| addr | input | 13 | Access address, sampled with the access |
| nv_busy | input | 1 | High while the nonvolatile controller runs an operation |
| store_req | output | 1 | One-cycle request to start a store |
| recall_req | output | 1 | One-cycle request to start a recall |

## Verification
The block is driven with complete store and recall chains, which show that only the sixth address decides the operation. It is also driven with chains broken by a write, by a stray read, by a repeated address or by a wrong final address; each of these must end with no request, and this separates a true abort from a counter that merely stalls. Chains broken by a read of the first address, including a doubled first read, must still complete, which tells the restart rule apart from a plain return to idle. Directed runs keep chip enable low while the address moves, and raise busy both between accesses and during the final access, to confirm that only enable falls are counted and that busy wipes out any partial progress.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

   localparam int SEQ_AW   = 13;
   localparam int PREFIX_N = 5;

   typedef logic [SEQ_AW-1:0] seq_addr_t;

   // common leading reads, order is significant
   localparam seq_addr_t PREFIX_ADDR [PREFIX_N] = '{
      13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0
   };

   // final read selects the operation
   localparam seq_addr_t STORE_ADDR  = 13'h0F0F;
   localparam seq_addr_t RECALL_ADDR = 13'h0F0E;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_STORE  = 2'd1,
      OP_RECALL = 2'd2
   } nv_op_e;

endpackage

// File: rtl/nvseq_access_sampler.sv
module nvseq_access_sampler #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              acc_vld,
   output logic              acc_wr,
   output logic [ADDR_W-1:0] acc_addr
);

   logic ce_hi_q;

   // remembers whether enable was high on the previous edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_hi_q <= 1'b0;
      end else begin
         ce_hi_q <= ce_n;
      end
   end

   assign acc_vld  = ce_hi_q & ~ce_n;
   assign acc_wr   = ~we_n;
   assign acc_addr = addr;

   // R1
   single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld |=> !acc_vld);

endmodule

// File: rtl/nvseq_step_match.sv
module nvseq_step_match
   import nvseq_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int STEP_W = 3
) (
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [STEP_W-1:0] step,
   output logic              hit_next,
   output logic              hit_first,
   output nv_op_e            final_op
);

   localparam int SLOTS = 1 << STEP_W;

   generate
      if (ADDR_W < SEQ_AW) begin : g_aw_bad
         $error("nvseq_step_match: ADDR_W narrower than sequence addresses");
      end
      if (SLOTS <= PREFIX_N) begin : g_step_bad
         $error("nvseq_step_match: STEP_W cannot index the final step");
      end
   endgenerate

   logic [SLOTS-1:0] hit_vec;

   // one comparator per prefix step; unused slots never match
   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
         if (i < PREFIX_N) begin : g_cmp
            assign hit_vec[i] = (acc_addr == ADDR_W'(PREFIX_ADDR[i]));
         end else begin : g_pad
            assign hit_vec[i] = 1'b0;
         end
      end
   endgenerate

   assign hit_next  = hit_vec[step];
   assign hit_first = hit_vec[0];

   always_comb begin
      if (acc_addr == ADDR_W'(STORE_ADDR)) begin
         final_op = OP_STORE;
      end else if (acc_addr == ADDR_W'(RECALL_ADDR)) begin
         final_op = OP_RECALL;
      end else begin
         final_op = OP_NONE;
      end
   end

endmodule

// File: rtl/nvseq_tracker.sv
module nvseq_tracker
   import nvseq_pkg::*;
#(
   parameter int STEP_W           = 3,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_busy,
   input  logic              acc_vld,
   input  logic              acc_wr,
   input  logic              hit_next,
   input  logic              hit_first,
   input  nv_op_e            final_op,
   output logic [STEP_W-1:0] step,
   output logic              store_req,
   output logic              recall_req
);

   localparam logic [STEP_W-1:0] FINAL_STEP = STEP_W'(PREFIX_N);
   localparam logic [STEP_W-1:0] IDLE_STEP  = '0;

   logic [STEP_W-1:0] restart_step;
   logic [STEP_W-1:0] step_nx;
   logic              store_nx;
   logic              recall_nx;

   // abort target: variant picked at elaboration
   generate
      if (RESTART_ON_FIRST) begin : g_restart
         assign restart_step = hit_first ? STEP_W'(1) : IDLE_STEP;
      end else begin : g_plain
         assign restart_step = IDLE_STEP;
      end
   endgenerate

   always_comb begin
      step_nx   = step;
      store_nx  = 1'b0;
      recall_nx = 1'b0;
      if (nv_busy) begin
         step_nx = IDLE_STEP;
      end else if (acc_vld) begin
         if (acc_wr) begin
            step_nx = IDLE_STEP;
         end else if (step == FINAL_STEP) begin
            unique case (final_op)
               OP_STORE: begin
                  step_nx  = IDLE_STEP;
                  store_nx = 1'b1;
               end
               OP_RECALL: begin
                  step_nx   = IDLE_STEP;
                  recall_nx = 1'b1;
               end
               default: step_nx = restart_step;
            endcase
         end else if (hit_next) begin
            step_nx = step + STEP_W'(1);
         end else begin
            step_nx = restart_step;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step       <= IDLE_STEP;
         store_req  <= 1'b0;
         recall_req <= 1'b0;
      end else begin
         step       <= step_nx;
         store_req  <= store_nx;
         recall_req <= recall_nx;
      end
   end

   // R8
   req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_req && recall_req));

   // R8
   store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> !store_req);

   // R8
   recall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> !recall_req);

   // R7
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_busy |=> (step == IDLE_STEP && !store_req && !recall_req));

   // R4
   write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_wr) |=> (step == IDLE_STEP && !store_req && !recall_req));

   // R2
   store_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> ($past(step) == FINAL_STEP));

   // R3
   recall_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |-> ($past(step) == FINAL_STEP));

   // R5
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step <= FINAL_STEP);

   // R5
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step != $past(step)) |->
         (step == IDLE_STEP || step == STEP_W'(1) || step == $past(step) + STEP_W'(1)));

endmodule

// File: rtl/nvseq_unlock_detector.sv
module nvseq_unlock_detector
   import nvseq_pkg::*;
#(
   parameter int ADDR_W           = 13,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              nv_busy,
   output logic              store_req,
   output logic              recall_req
);

   localparam int STEP_W = $clog2(PREFIX_N + 1);

   logic              acc_vld;
   logic              acc_wr;
   logic [ADDR_W-1:0] acc_addr;
   logic [STEP_W-1:0] step;
   logic              hit_next;
   logic              hit_first;
   nv_op_e            final_op;

   nvseq_access_sampler #(
      .ADDR_W (ADDR_W)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .addr     (addr),
      .acc_vld  (acc_vld),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr)
   );

   nvseq_step_match #(
      .ADDR_W (ADDR_W),
      .STEP_W (STEP_W)
   ) u_match (
      .acc_addr  (acc_addr),
      .step      (step),
      .hit_next  (hit_next),
      .hit_first (hit_first),
      .final_op  (final_op)
   );

   nvseq_tracker #(
      .STEP_W           (STEP_W),
      .RESTART_ON_FIRST (RESTART_ON_FIRST)
   ) u_tracker (
      .clk        (clk),
      .rst_n      (rst_n),
      .nv_busy    (nv_busy),
      .acc_vld    (acc_vld),
      .acc_wr     (acc_wr),
      .hit_next   (hit_next),
      .hit_first  (hit_first),
      .final_op   (final_op),
      .step       (step),
      .store_req  (store_req),
      .recall_req (recall_req)
   );

endmodule

// File: tb/nvseq_unlock_detector_bench.sv
module nvseq_unlock_detector_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        we_n = 1'b1;
   logic [12:0] addr = '0;
   logic        nv_busy = 1'b0;
   logic        store_req;
   logic        recall_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   nvseq_unlock_detector u_nvseq_unlock_detector (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .we_n       (we_n),
      .addr       (addr),
      .nv_busy    (nv_busy),
      .store_req  (store_req),
      .recall_req (recall_req)
   );

   // entry: {req[3:0], write, addr[12:0], expected {store,recall}}
   localparam int NV = 63;
   localparam logic [19:0] VEC [NV] = '{
      // R2 full store chain
      {4'd2,1'b0,13'h0000,2'b00}, {4'd2,1'b0,13'h1555,2'b00}, {4'd2,1'b0,13'h0AAA,2'b00},
      {4'd2,1'b0,13'h1FFF,2'b00}, {4'd2,1'b0,13'h10F0,2'b00}, {4'd2,1'b0,13'h0F0F,2'b10},
      // R3 full recall chain
      {4'd3,1'b0,13'h0000,2'b00}, {4'd3,1'b0,13'h1555,2'b00}, {4'd3,1'b0,13'h0AAA,2'b00},
      {4'd3,1'b0,13'h1FFF,2'b00}, {4'd3,1'b0,13'h10F0,2'b00}, {4'd3,1'b0,13'h0F0E,2'b01},
      // R4 write in the middle
      {4'd4,1'b0,13'h0000,2'b00}, {4'd4,1'b0,13'h1555,2'b00}, {4'd4,1'b1,13'h0AAA,2'b00},
      {4'd4,1'b0,13'h0AAA,2'b00}, {4'd4,1'b0,13'h1FFF,2'b00}, {4'd4,1'b0,13'h10F0,2'b00},
      {4'd4,1'b0,13'h0F0F,2'b00},
      // R5 stray read
      {4'd5,1'b0,13'h0000,2'b00}, {4'd5,1'b0,13'h1555,2'b00}, {4'd5,1'b0,13'h0123,2'b00},
      {4'd5,1'b0,13'h0AAA,2'b00}, {4'd5,1'b0,13'h1FFF,2'b00}, {4'd5,1'b0,13'h10F0,2'b00},
      {4'd5,1'b0,13'h0F0F,2'b00},
      // R6 abort by first address restarts
      {4'd6,1'b0,13'h0000,2'b00}, {4'd6,1'b0,13'h1555,2'b00}, {4'd6,1'b0,13'h0AAA,2'b00},
      {4'd6,1'b0,13'h0000,2'b00}, {4'd6,1'b0,13'h1555,2'b00}, {4'd6,1'b0,13'h0AAA,2'b00},
      {4'd6,1'b0,13'h1FFF,2'b00}, {4'd6,1'b0,13'h10F0,2'b00}, {4'd6,1'b0,13'h0F0F,2'b10},
      // R5 repeated address
      {4'd5,1'b0,13'h0000,2'b00}, {4'd5,1'b0,13'h1555,2'b00}, {4'd5,1'b0,13'h1555,2'b00},
      {4'd5,1'b0,13'h0AAA,2'b00}, {4'd5,1'b0,13'h1FFF,2'b00}, {4'd5,1'b0,13'h10F0,2'b00},
      {4'd5,1'b0,13'h0F0F,2'b00},
      // R9 wrong final address
      {4'd9,1'b0,13'h0000,2'b00}, {4'd9,1'b0,13'h1555,2'b00}, {4'd9,1'b0,13'h0AAA,2'b00},
      {4'd9,1'b0,13'h1FFF,2'b00}, {4'd9,1'b0,13'h10F0,2'b00}, {4'd9,1'b0,13'h0F0D,2'b00},
      {4'd9,1'b0,13'h0F0F,2'b00},
      // R4 write to the final address
      {4'd4,1'b0,13'h0000,2'b00}, {4'd4,1'b0,13'h1555,2'b00}, {4'd4,1'b0,13'h0AAA,2'b00},
      {4'd4,1'b0,13'h1FFF,2'b00}, {4'd4,1'b0,13'h10F0,2'b00}, {4'd4,1'b1,13'h0F0F,2'b00},
      {4'd4,1'b0,13'h0F0F,2'b00},
      // R6 doubled first read
      {4'd6,1'b0,13'h0000,2'b00}, {4'd6,1'b0,13'h0000,2'b00}, {4'd6,1'b0,13'h1555,2'b00},
      {4'd6,1'b0,13'h0AAA,2'b00}, {4'd6,1'b0,13'h1FFF,2'b00}, {4'd6,1'b0,13'h10F0,2'b00},
      {4'd6,1'b0,13'h0F0E,2'b01}
   };

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual {store,recall}=%b expected=%b", tag, act, exp);
      end
   endtask

   // one enable pulse; returns outputs seen after the sampling edge and one cycle later
   task automatic access(input logic [12:0] a, input logic wr,
                         output logic [1:0] now_o, output logic [1:0] next_o);
      @(negedge clk);
      addr = a;
      we_n = ~wr;
      ce_n = 1'b0;
      @(negedge clk);
      now_o = {store_req, recall_req};
      ce_n  = 1'b1;
      @(negedge clk);
      next_o = {store_req, recall_req};
      we_n   = 1'b1;
   endtask

   task automatic prefix5();
      logic [1:0] n0, n1;
      access(13'h0000, 1'b0, n0, n1);
      access(13'h1555, 1'b0, n0, n1);
      access(13'h0AAA, 1'b0, n0, n1);
      access(13'h1FFF, 1'b0, n0, n1);
      access(13'h10F0, 1'b0, n0, n1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [1:0] o_now, o_next;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 reset outputs", {store_req, recall_req}, 2'b00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 after reset release", {store_req, recall_req}, 2'b00);

      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         v = VEC[i];
         access(v[14:2], v[15], o_now, o_next);
         check($sformatf("R%0d vector %0d", v[19:16], i), o_now, v[1:0]);
         if (v[1:0] != 2'b00) begin
            // R8 pulse lasts one cycle
            check($sformatf("R8 pulse width vector %0d", i), o_next, 2'b00);
         end
      end

      // R1 enable held low while the address moves to the store address
      prefix5();
      @(negedge clk);
      addr = 13'h1234;
      ce_n = 1'b0;
      @(negedge clk);
      check("R1 held enable first access", {store_req, recall_req}, 2'b00);
      addr = 13'h0F0F;
      @(negedge clk);
      check("R1 held enable address change", {store_req, recall_req}, 2'b00);
      @(negedge clk);
      check("R1 held enable still low", {store_req, recall_req}, 2'b00);
      ce_n = 1'b1;
      access(13'h0F0F, 1'b0, o_now, o_next);
      check("R1 held enable not counted twice", o_now, 2'b00);

      // R7 busy between accesses wipes progress
      prefix5();
      @(negedge clk);
      nv_busy = 1'b1;
      @(negedge clk);
      nv_busy = 1'b0;
      access(13'h0F0F, 1'b0, o_now, o_next);
      check("R7 busy clears progress", o_now, 2'b00);

      // R7 busy during the final access
      prefix5();
      nv_busy = 1'b1;
      access(13'h0F0E, 1'b0, o_now, o_next);
      check("R7 access ignored while busy", o_now, 2'b00);
      nv_busy = 1'b0;
      access(13'h0F0E, 1'b0, o_now, o_next);
      check("R7 no stale progress after busy", o_now, 2'b00);

      // R2 chain works again after busy
      prefix5();
      access(13'h0F0F, 1'b0, o_now, o_next);
      check("R2 store after busy recovery", o_now, 2'b10);
      check("R8 store pulse one cycle", o_next, 2'b00);

      // R6 first address at the final step restarts
      prefix5();
      access(13'h0000, 1'b0, o_now, o_next);
      access(13'h1555, 1'b0, o_now, o_next);
      access(13'h0AAA, 1'b0, o_now, o_next);
      access(13'h1FFF, 1'b0, o_now, o_next);
      access(13'h10F0, 1'b0, o_now, o_next);
      access(13'h0F0E, 1'b0, o_now, o_next);
      check("R6 restart from final step", o_now, 2'b01);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule